// File: doc/BRIEF.md
# Three-Lane 7:1 Framed Deserializer

This block turns three serial data lanes into one 21-bit parallel word. A fourth lane carries a serial copy of the link clock. All four lanes are sampled by a bit clock running at seven times the link clock rate. The clock lane repeats a fixed seven-bit shape once per word, and the block takes its word boundary from that shape rather than from a free-running counter. At every boundary the seven bits just collected on each lane are moved into a parallel output register. A word clock at the link rate rises on the same edge, so the data is settled well before that clock falls.

Each lane has a digital "not connected" flag. A flagged lane is read as zeros. An active-low shutdown input clears all internal state and the output word, and holds the word clock low. After shutdown is released, the block must lock onto the framing again before any data appears.

Top module: `lvds_deser7`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `word_o`, `word_clk_o` and `locked_o` are 0 until framing is acquired.
- R2: While locked, `word_clk_o` repeats every 7 bit-clock cycles. It is high for 4 cycles and low for 3, and it rises on the edge where `word_o` takes a new word. It is low whenever `locked_o` is low.
- R3: `word_o` changes only on a bit-clock edge where `word_clk_o` rises, or when it is cleared. It holds its value for the whole word period in between.
- R4: Within each lane, the first bit received in a word becomes bit 0 of that lane's 7-bit field. Lane 0 fills `word_o[6:0]`, lane 1 fills `word_o[13:7]` and lane 2 fills `word_o[20:14]`.
- R5: A word boundary is the bit-clock edge where the last seven clock-lane samples are 1,1,0,0,0,1,1 in order of arrival. The boundary is found at any bit offset.
- R6: `locked_o` goes high on the second consecutive boundary whose clock-lane pattern matches. On that same edge `word_o` takes the word that arrived with that pattern. Before this, `word_o` stays 0 and `locked_o` stays 0.
- R7: If the clock-lane pattern does not match at an expected boundary, `locked_o` drops on that edge and `word_clk_o` stays low. `word_o` keeps the last good word, and two consecutive matched words are needed to lock again.
- R8: While `open_i[k]` is 1, every bit of lane k's field is captured as 0.
- R9: On the edge after `shdn_ni` is sampled low, and for as long as it stays low, `word_o`, `locked_o` and `word_clk_o` are 0.
- R10: After `shdn_ni` returns high, framing search starts from scratch. One matched word does not lock, and the second matched word locks and is output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, 7x the link clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shdn_ni | input | 1 | Active-low shutdown / clear |
| lane_i | input | 3 | Serial data lanes, one bit per lane per bit clock |
| clk_lane_i | input | 1 | Sampled serial copy of the link clock |
| open_i | input | 3 | Per-lane not-connected flag |
| word_o | output | 21 | Recovered parallel word |
| word_clk_o | output | 1 | Word clock at the link rate |
| locked_o | output | 1 | Framing acquired |

## Verification
The word and the rise of `word_clk_o` both come from the edge that samples the seventh bit of a word, so they are due one register after the last bit. The bench drives each bit after a falling edge and checks the result after the next falling edge. The clock high count and the stability of `word_o` are sampled once per bit across each following word, in phases 0 to 6. The effects of shutdown are due one edge after it is sampled low, and they are checked at the first falling edge after that.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int NUM_LANES = 3;
  localparam int LANE_BITS = 7;
  // clock-lane shape, bit 0 arrives first
  localparam logic [LANE_BITS-1:0] FRAME_PAT = 7'b1100011;
endpackage

// File: rtl/lane_shift.sv
module lane_shift #(
  parameter int W = deser_pkg::LANE_BITS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         bit_i,
  input  logic         open_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] sr_q;

  // first-received bit ends up at bit 0
  assign nxt_o = {bit_i & ~open_i, sr_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (clr_i) sr_q <= '0;
    else            sr_q <= nxt_o;
  end
endmodule

// File: rtl/frame_track.sv
module frame_track #(
  parameter int           W          = deser_pkg::LANE_BITS,
  parameter logic [W-1:0] PAT        = deser_pkg::FRAME_PAT,
  parameter int           LOCK_WORDS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic clk_lane_i,
  output logic capture_o,
  output logic locked_o,
  output logic wclk_o
);
  localparam int PH_W  = $clog2(W);
  localparam int CNT_W = $clog2(LOCK_WORDS + 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(W - 1);
  localparam logic [PH_W-1:0]  PH_HI   = PH_W'((W + 1) / 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_WORDS);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(LOCK_WORDS - 1);

  logic [W-1:0]     hist_q, hist_d;
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trk_q, trk_d;
  logic             lock_q, lock_d;
  logic             wclk_q, wclk_d;
  logic             match, cap;

  always_comb begin
    hist_d  = {clk_lane_i, hist_q[W-1:1]};
    match   = (hist_d == PAT);
    phase_d = phase_q;
    cnt_d   = cnt_q;
    trk_d   = trk_q;
    lock_d  = lock_q;
    cap     = 1'b0;
    if (!trk_q) begin
      if (match) begin
        trk_d   = 1'b1;
        phase_d = '0;
        cnt_d   = CNT_W'(1);
        if (LOCK_WORDS <= 1) begin
          lock_d = 1'b1;
          cap    = 1'b1;
        end
      end
    end else begin
      phase_d = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
      if (phase_q == PH_LAST) begin
        if (match) begin
          if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
          if (cnt_q >= CNT_PRE) begin
            lock_d = 1'b1;
            cap    = 1'b1;
          end
        end else begin
          trk_d  = 1'b0;
          cnt_d  = '0;
          lock_d = 1'b0;
        end
      end
    end
    wclk_d = lock_d && (phase_d < PH_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      phase_q <= '0;
      cnt_q   <= '0;
      trk_q   <= 1'b0;
      lock_q  <= 1'b0;
      wclk_q  <= 1'b0;
    end else if (clr_i) begin
      hist_q  <= '0;
      phase_q <= '0;
      cnt_q   <= '0;
      trk_q   <= 1'b0;
      lock_q  <= 1'b0;
      wclk_q  <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      trk_q   <= trk_d;
      lock_q  <= lock_d;
      wclk_q  <= wclk_d;
    end
  end

  assign capture_o = cap & ~clr_i;
  assign locked_o  = lock_q;
  assign wclk_o    = wclk_q;
endmodule

// File: rtl/word_hold.sv
module word_hold #(
  parameter int WW = deser_pkg::NUM_LANES * deser_pkg::LANE_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [WW-1:0] din_i,
  output logic [WW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (load_i) q_o <= din_i;
  end
endmodule

// File: rtl/lvds_deser7.sv
module lvds_deser7 #(
  parameter int NUM_LANES  = deser_pkg::NUM_LANES,
  parameter int LANE_BITS  = deser_pkg::LANE_BITS,
  parameter int LOCK_WORDS = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           shdn_ni,
  input  logic [NUM_LANES-1:0]           lane_i,
  input  logic                           clk_lane_i,
  input  logic [NUM_LANES-1:0]           open_i,
  output logic [NUM_LANES*LANE_BITS-1:0] word_o,
  output logic                           word_clk_o,
  output logic                           locked_o
);
  localparam int WW = NUM_LANES * LANE_BITS;

  logic          clr;
  logic          capture;
  logic [WW-1:0] lanes_nxt;

  assign clr = ~shdn_ni;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lane_shift #(.W(LANE_BITS)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .bit_i  (lane_i[g]),
      .open_i (open_i[g]),
      .nxt_o  (lanes_nxt[g*LANE_BITS +: LANE_BITS])
    );
  end

  frame_track #(.W(LANE_BITS), .LOCK_WORDS(LOCK_WORDS)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .clk_lane_i (clk_lane_i),
    .capture_o  (capture),
    .locked_o   (locked_o),
    .wclk_o     (word_clk_o)
  );

  word_hold #(.WW(WW)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .load_i (capture),
    .din_i  (lanes_nxt),
    .q_o    (word_o)
  );
endmodule

// File: rtl/lvds_deser7_chk.sv
module lvds_deser7_chk #(
  parameter int WW = 21
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          shdn_ni,
  input logic [WW-1:0] word_o,
  input logic          word_clk_o,
  input logic          locked_o
);
  assert_shdn_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_ni |=> (word_o == '0) && !locked_o && !word_clk_o);

  assert_wclk_needs_lock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_clk_o |-> locked_o);

  assert_word_at_wclk_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(word_o) |-> $rose(word_clk_o) || (word_o == '0));

  assert_word_zero_unlocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(word_o) |-> locked_o || (word_o == '0));

  assert_unlock_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(locked_o) && $past(shdn_ni)) |-> $stable(word_o));
endmodule

bind lvds_deser7 lvds_deser7_chk #(.WW(NUM_LANES * LANE_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shdn_ni    (shdn_ni),
  .word_o     (word_o),
  .word_clk_o (word_clk_o),
  .locked_o   (locked_o)
);

// File: tb/tb_lvds_deser7.sv
module tb_lvds_deser7;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] PAT = 7'b1100011;

  typedef struct packed {
    logic [20:0] din;
    logic [2:0]  opn;
    logic [20:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{21'h1FFFFF, 3'b000, 21'h1FFFFF},
    '{21'h000001, 3'b000, 21'h000001},
    '{21'h100000, 3'b000, 21'h100000},
    '{21'h0AAAAA, 3'b000, 21'h0AAAAA},
    '{21'h155555, 3'b000, 21'h155555},
    '{21'h1FFFFF, 3'b010, 21'h1FC07F},
    '{21'h1FFFFF, 3'b101, 21'h003F80},
    '{21'h0F0F0F, 3'b001, 21'h0F0F00}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        shdn_ni = 1'b1;
  logic [2:0]  lane_i = '0;
  logic        clk_lane_i = 1'b0;
  logic [2:0]  open_i = '0;
  logic [20:0] word_o;
  logic        word_clk_o;
  logic        locked_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvds_deser7 dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .shdn_ni    (shdn_ni),
    .lane_i     (lane_i),
    .clk_lane_i (clk_lane_i),
    .open_i     (open_i),
    .word_o     (word_o),
    .word_clk_o (word_clk_o),
    .locked_o   (locked_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one word: 7 bits driven after negedges, ends just after the boundary edge
  task automatic send_word(input logic [20:0] d, input logic [2:0] op, input logic good,
                           output int highs, output logic steady);
    logic [20:0] w0;
    w0 = '0;
    highs = 0;
    steady = 1'b1;
    for (int b = 0; b < 7; b++) begin
      if (word_clk_o) highs++;
      if (b == 0) w0 = word_o;
      else if (word_o !== w0) steady = 1'b0;
      lane_i     = {d[14+b], d[7+b], d[b]};
      clk_lane_i = good ? PAT[b] : 1'b0;
      open_i     = op;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      lane_i = 3'b101; clk_lane_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    int   hi;
    logic st;
    repeat (3) @(negedge clk);
    chk("R1 word in reset", 32'(word_o), 0);
    chk("R1 locked in reset", 32'(locked_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 wclk after reset", 32'(word_clk_o), 0);

    idle(3);  // odd offset for R5
    send_word(21'h0ABCDE, 3'b000, 1'b1, hi, st);
    chk("R6 not locked after one word", 32'(locked_o), 0);
    chk("R6 word zero before lock", 32'(word_o), 0);
    chk("R2 wclk low before lock", 32'(hi), 0);
    send_word(21'h013579, 3'b000, 1'b1, hi, st);
    chk("R5 R6 locked after two words", 32'(locked_o), 1);
    chk("R4 R6 lock word", 32'(word_o), 32'h013579);
    chk("R2 wclk rises with word", 32'(word_clk_o), 1);

    for (int i = 0; i < 8; i++) begin
      send_word(VEC[i].din, VEC[i].opn, 1'b1, hi, st);
      chk("R4 R8 word", 32'(word_o), 32'(VEC[i].exp));
      chk("R2 wclk high count", 32'(hi), 4);
      chk("R3 word steady in period", 32'(st), 1);
    end
    open_i = '0;

    send_word(21'h1F00F1, 3'b000, 1'b0, hi, st);
    chk("R7 lock drops", 32'(locked_o), 0);
    chk("R7 word held", 32'(word_o), 32'h0F0F00);
    chk("R7 wclk low", 32'(word_clk_o), 0);
    send_word(21'h111111, 3'b000, 1'b1, hi, st);
    chk("R7 one word no relock", 32'(locked_o), 0);
    chk("R7 word still held", 32'(word_o), 32'h0F0F00);
    chk("R7 wclk idle", 32'(hi), 0);
    send_word(21'h0C3A5F, 3'b000, 1'b1, hi, st);
    chk("R7 relocked", 32'(locked_o), 1);
    chk("R7 new word", 32'(word_o), 32'h0C3A5F);

    shdn_ni = 1'b0;
    lane_i = 3'b111; clk_lane_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 word cleared", 32'(word_o), 0);
    chk("R9 unlocked", 32'(locked_o), 0);
    chk("R9 wclk low", 32'(word_clk_o), 0);
    send_word(21'h1ABCDE, 3'b000, 1'b1, hi, st);
    chk("R9 wclk stays low", 32'(hi), 0);
    chk("R9 word stays zero", 32'(word_o), 0);
    shdn_ni = 1'b1;
    idle(2);
    send_word(21'h055AA5, 3'b000, 1'b1, hi, st);
    chk("R10 no lock after one word", 32'(locked_o), 0);
    chk("R10 word zero", 32'(word_o), 0);
    send_word(21'h1E1E1E, 3'b000, 1'b1, hi, st);
    chk("R10 relocked", 32'(locked_o), 1);
    chk("R10 first word", 32'(word_o), 32'h1E1E1E);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule